// File: doc/BRIEF.md
# Interrupt Event Queue Writer with Pending Counter

This block records standard-priority interrupt events as two-word entries in a shared RAM that works as a first-in-first-out queue. When an event is offered and the engine is idle, it captures the event's status word and its block pointer. It then writes the pointer word at one past the tail address and, in the next cycle, writes the status word at the tail address with its valid flag (bit 15) forced high. Because the status word is written last, a reader that polls that flag never sees a half-written entry. When the status write finishes, the tail advances by two words and the pending counter goes up by one.

A host reads and controls the block through a small register port. It can load and read the tail address and read the pending count with its overflow flag. A write to the counter register clears the count. Any access to a separate auto-decrement register retires one entry. The counter holds at most 255 entries. An entry that completes while the counter is full leaves the count at 255 and sets a sticky overflow flag.

Top module: `iq_queue`

## Requirements
- R1: After reset the count is 0, the overflow flag is 0, the tail address is 0, `evt_ready` is 1 and `ram_we` is 0.
- R2: An event is accepted on a clock edge where `evt_valid` and `evt_ready` are both 1. `evt_ready` is then 0 for the next two cycles and returns to 1 in the third.
- R3: In the first cycle after acceptance the block writes the event pointer at address tail+1.
- R4: In the second cycle after acceptance the block writes the status word at address tail. Bits 14..0 come from the event and bit 15 is forced to 1.
- R5: At the end of the second write cycle the tail advances by 2 and the count increases by 1.
- R6: Register select codes are: 0 = tail address, 1 = counter, 2 = auto-decrement, 3 = unused. A read of the counter or auto-decrement register returns the count in bits 7..0, the overflow flag in bit 8 and zeros above. A read of code 3 returns 0.
- R7: The count saturates at 255. An entry that completes while the count is 255 leaves it at 255 and sets the overflow flag, which stays set until it is cleared.
- R8: A host write to the counter register clears both the count and the overflow flag. The clear wins over an entry completing in the same cycle.
- R9: Each cycle with a read or a write of the auto-decrement register lowers the count by one. The read returns the value before the decrement, and the overflow flag is not changed.
- R10: A decrement while the count is 0 has no effect.
- R11: If an entry completes in the same cycle as a decrement, the count is left unchanged.
- R12: A host write to the tail register loads the tail address. The load wins over the advance of an entry that completes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| evt_valid | input | 1 | Event offered |
| evt_status | input | 16 | Event status word; bits 14..0 are stored |
| evt_ptr | input | 16 | Associated block pointer |
| evt_ready | output | 1 | Engine idle; an offered event is accepted |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 16 | RAM word address |
| ram_wdata | output | 16 | RAM write data |
| hst_sel | input | 2 | Register select |
| hst_rd | input | 1 | Host read strobe |
| hst_wr | input | 1 | Host write strobe |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data (combinational from the select) |

## Verification
The RAM pointer write is due one cycle after the accepting edge and the status write two cycles after it. The tail and count change on the edge that ends the status write, so they can be read three cycles after acceptance. Host read data is combinational and is sampled 1 ns after the select is driven. Register effects of an access show one cycle later. The bench drives on falling edges and samples at exactly these falling edges. It collides host accesses with the status-write cycle to check the ordering rules, and it sweeps the count from 0 through overflow and back down past zero against an arithmetic model.

// File: rtl/iq_pkg.sv
package iq_pkg;
  typedef enum logic [1:0] {
    SEL_TAIL    = 2'd0,
    SEL_COUNT   = 2'd1,
    SEL_AUTODEC = 2'd2,
    SEL_NONE    = 2'd3
  } iq_sel_e;

  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_PTR  = 2'd1,
    WS_STAT = 2'd2
  } iq_wstate_e;

  localparam int unsigned ENTRY_WORDS = 2;
endpackage

// File: rtl/iq_rst_sync.sv
module iq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/iq_count.sv
module iq_count #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  input  logic          clr,
  output logic [CW-1:0] cnt,
  output logic          exceed
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] cnt_q, cnt_d;
  logic          exc_q, exc_d;
  logic          en;

  assign en = clr | inc | dec;

  always_comb begin
    cnt_d = cnt_q;
    exc_d = exc_q;
    if (clr) begin
      cnt_d = '0;
      exc_d = 1'b0;
    end else if (inc && !dec) begin
      if (cnt_q == CMAX) exc_d = 1'b1;
      else               cnt_d = cnt_q + 1'b1;
    end else if (dec && !inc && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exc_q <= 1'b0;
    end else if (en) begin
      cnt_q <= cnt_d;
      exc_q <= exc_d;
    end
  end

  assign cnt    = cnt_q;
  assign exceed = exc_q;

  // R7: a full counter holds and flags overflow
  p_saturate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CMAX && inc && !dec && !clr) |=> (cnt_q == CMAX && exc_q));
  // R7: overflow flag is sticky until cleared
  p_exceed_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_q && !clr) |=> exc_q);
  // R10: no underflow
  p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && dec && !inc && !clr) |=> (cnt_q == '0));
  // R11: simultaneous entry and decrement cancel
  p_inc_dec_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec && !clr) |=> $stable(cnt_q));
  // R8: clear empties the counter
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0 && !exc_q));
endmodule

// File: rtl/iq_writer.sv
module iq_writer
  import iq_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_valid,
  input  logic [DW-1:0] evt_status,
  input  logic [AW-1:0] evt_ptr,
  output logic          evt_ready,
  input  logic          tail_ld,
  input  logic [AW-1:0] tail_ld_val,
  output logic [AW-1:0] tail,
  output logic          done,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata
);
  localparam logic [AW-1:0] STEP = AW'(ENTRY_WORDS);

  iq_wstate_e    st_q, st_d;
  logic [AW-1:0] tail_q, tail_d;
  logic [DW-2:0] stat_q;
  logic [AW-1:0] ptr_q;
  logic          cap;
  logic          tail_en;

  assign evt_ready = (st_q == WS_IDLE);
  assign cap       = evt_valid && evt_ready;
  assign done      = (st_q == WS_STAT);

  always_comb begin
    st_d   = st_q;
    tail_d = tail_q;
    case (st_q)
      WS_IDLE: if (cap) st_d = WS_PTR;
      WS_PTR:  st_d = WS_STAT;
      WS_STAT: begin
        st_d   = WS_IDLE;
        tail_d = tail_q + STEP;
      end
      default: st_d = WS_IDLE;
    endcase
    if (tail_ld) tail_d = tail_ld_val;
  end

  assign tail_en = tail_ld || done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= WS_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tail_q <= '0;
    else if (tail_en) tail_q <= tail_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      ptr_q  <= '0;
    end else if (cap) begin
      stat_q <= evt_status[DW-2:0];
      ptr_q  <= evt_ptr;
    end
  end

  assign tail      = tail_q;
  assign ram_we    = (st_q == WS_PTR) || (st_q == WS_STAT);
  assign ram_addr  = (st_q == WS_PTR) ? (tail_q + 1'b1) : tail_q;
  assign ram_wdata = (st_q == WS_PTR) ? DW'(ptr_q) : {1'b1, stat_q};

  // R2: two busy cycles after acceptance
  p_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_ready) |=> !evt_ready ##1 !evt_ready ##1 evt_ready);
  // R3: no RAM write while idle
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> !evt_ready);
  // R5: tail advances by one entry unless loaded
  p_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !tail_ld) |=> (tail_q == $past(tail_q) + STEP));
  // R12: host load wins
  p_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tail_ld |=> (tail_q == $past(tail_ld_val)));
endmodule

// File: rtl/iq_hostif.sv
module iq_hostif
  import iq_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 8
) (
  input  logic [1:0]    hst_sel,
  input  logic          hst_rd,
  input  logic          hst_wr,
  input  logic [DW-1:0] hst_wdata,
  input  logic [AW-1:0] tail,
  input  logic [CW-1:0] cnt,
  input  logic          exceed,
  output logic          cnt_dec,
  output logic          cnt_clr,
  output logic          tail_ld,
  output logic [AW-1:0] tail_ld_val,
  output logic [DW-1:0] hst_rdata
);
  iq_sel_e sel;
  logic    acc;

  assign sel         = iq_sel_e'(hst_sel);
  assign acc         = hst_rd || hst_wr;
  assign cnt_dec     = acc && (sel == SEL_AUTODEC);
  assign cnt_clr     = hst_wr && (sel == SEL_COUNT);
  assign tail_ld     = hst_wr && (sel == SEL_TAIL);
  assign tail_ld_val = hst_wdata[AW-1:0];

  always_comb begin
    case (sel)
      SEL_TAIL:                hst_rdata = DW'(tail);
      SEL_COUNT, SEL_AUTODEC:  hst_rdata = DW'({exceed, cnt});
      default:                 hst_rdata = '0;
    endcase
  end
endmodule

// File: rtl/iq_queue.sv
module iq_queue #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_valid,
  input  logic [DW-1:0] evt_status,
  input  logic [AW-1:0] evt_ptr,
  output logic          evt_ready,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  input  logic [1:0]    hst_sel,
  input  logic          hst_rd,
  input  logic          hst_wr,
  input  logic [DW-1:0] hst_wdata,
  output logic [DW-1:0] hst_rdata
);
  logic          rst_n_s;
  logic [AW-1:0] tail;
  logic          done;
  logic [CW-1:0] cnt;
  logic          exceed;
  logic          cnt_dec, cnt_clr, tail_ld;
  logic [AW-1:0] tail_ld_val;

  iq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  iq_writer #(.AW(AW), .DW(DW)) u_writer (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .evt_valid   (evt_valid),
    .evt_status  (evt_status),
    .evt_ptr     (evt_ptr),
    .evt_ready   (evt_ready),
    .tail_ld     (tail_ld),
    .tail_ld_val (tail_ld_val),
    .tail        (tail),
    .done        (done),
    .ram_we      (ram_we),
    .ram_addr    (ram_addr),
    .ram_wdata   (ram_wdata)
  );

  iq_count #(.CW(CW)) u_count (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .inc    (done),
    .dec    (cnt_dec),
    .clr    (cnt_clr),
    .cnt    (cnt),
    .exceed (exceed)
  );

  iq_hostif #(.AW(AW), .DW(DW), .CW(CW)) u_host (
    .hst_sel     (hst_sel),
    .hst_rd      (hst_rd),
    .hst_wr      (hst_wr),
    .hst_wdata   (hst_wdata),
    .tail        (tail),
    .cnt         (cnt),
    .exceed      (exceed),
    .cnt_dec     (cnt_dec),
    .cnt_clr     (cnt_clr),
    .tail_ld     (tail_ld),
    .tail_ld_val (tail_ld_val),
    .hst_rdata   (hst_rdata)
  );
endmodule

// File: tb/test_iq_queue.sv
module test_iq_queue;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        evt_valid;
  logic [15:0] evt_status, evt_ptr;
  logic        evt_ready, ram_we;
  logic [15:0] ram_addr, ram_wdata;
  logic [1:0]  hst_sel;
  logic        hst_rd, hst_wr;
  logic [15:0] hst_wdata, hst_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  int exp_cnt = 0;
  int exp_exc = 0;
  logic [15:0] exp_tail = 16'h0000;

  always #4 clk = ~clk;

  iq_queue i_iq_queue (
    .clk(clk), .rst_n(rst_n),
    .evt_valid(evt_valid), .evt_status(evt_status), .evt_ptr(evt_ptr),
    .evt_ready(evt_ready),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .hst_sel(hst_sel), .hst_rd(hst_rd), .hst_wr(hst_wr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] cnt_word();
    return 16'((exp_exc << 8) | exp_cnt);
  endfunction

  // One host access; returns combinational read data; effect visible after.
  task automatic host(input logic [1:0] sel, input logic rd, input logic wr,
                      input logic [15:0] wd, output logic [15:0] rdv);
    @(negedge clk);
    hst_sel = sel; hst_rd = rd; hst_wr = wr; hst_wdata = wd;
    #1 rdv = hst_rdata;
    @(negedge clk);
    hst_rd = 1'b0; hst_wr = 1'b0;
  endtask

  task automatic check_count(input string req);
    logic [15:0] v;
    host(2'd1, 1'b1, 1'b0, 16'h0, v);
    chk(req, 32'(v), 32'(cnt_word()));
  endtask

  // Push one event; optional host access collides with the status-write cycle.
  task automatic push(input logic [15:0] st, input logic [15:0] p,
                      input logic side, input logic [1:0] ssel,
                      input logic srd, input logic swr, input logic [15:0] swd);
    @(negedge clk);
    evt_valid = 1'b1; evt_status = st; evt_ptr = p;
    @(negedge clk);
    evt_valid = 1'b0;
    chk("R2 ready low 1", 32'(evt_ready), 32'd0);
    chk("R3 ptr write", {15'd0, ram_we, ram_addr}, {15'd0, 1'b1, 16'(exp_tail + 16'd1)});
    chk("R3 ptr data", 32'(ram_wdata), 32'(p));
    @(negedge clk);
    chk("R2 ready low 2", 32'(evt_ready), 32'd0);
    chk("R4 stat write", {15'd0, ram_we, ram_addr}, {15'd0, 1'b1, exp_tail});
    chk("R4 stat data", 32'(ram_wdata), 32'({1'b1, st[14:0]}));
    if (side) begin
      hst_sel = ssel; hst_rd = srd; hst_wr = swr; hst_wdata = swd;
    end
    @(negedge clk);
    hst_rd = 1'b0; hst_wr = 1'b0;
    chk("R2 ready back", 32'(evt_ready), 32'd1);
    chk("R5 quiet after entry", 32'(ram_we), 32'd0);
  endtask

  task automatic model_inc();
    if (exp_cnt == 255) exp_exc = 1; else exp_cnt++;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : stim
    logic [15:0] v;
    rst_n = 1'b0; evt_valid = 1'b0; evt_status = '0; evt_ptr = '0;
    hst_sel = '0; hst_rd = 1'b0; hst_wr = 1'b0; hst_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    @(negedge clk);
    chk("R1 ready", 32'(evt_ready), 32'd1);
    chk("R1 no write", 32'(ram_we), 32'd0);
    host(2'd0, 1'b1, 1'b0, 16'h0, v);
    chk("R1 tail", 32'(v), 32'd0);
    check_count("R1 count");

    // R12 load tail, R6 readback
    host(2'd0, 1'b0, 1'b1, 16'h1000, v);
    exp_tail = 16'h1000;
    host(2'd0, 1'b1, 1'b0, 16'h0, v);
    chk("R12 tail load", 32'(v), 32'h1000);
    host(2'd3, 1'b1, 1'b0, 16'h0, v);
    chk("R6 unused reads 0", 32'(v), 32'd0);

    // R5 R7 sweep through overflow
    for (int i = 0; i < 300; i++) begin
      push(16'((i * 16'h0123) ^ 16'h7A5C), 16'(16'hA000 + i), 1'b0, 2'd0, 1'b0, 1'b0, 16'h0);
      model_inc();
      exp_tail = exp_tail + 16'd2;
      check_count("R5 R7 count");
      if (i % 37 == 0 || i >= 253) begin
        host(2'd0, 1'b1, 1'b0, 16'h0, v);
        chk("R5 tail", 32'(v), 32'(exp_tail));
      end
    end

    // R9 decrement down, R10 past zero, alternating read and write access
    for (int i = 0; i < 260; i++) begin
      host(2'd2, (i % 2 == 0), (i % 2 != 0), 16'hFFFF, v);
      if (i % 2 == 0) chk("R9 autodec read value", 32'(v), 32'(cnt_word()));
      if (exp_cnt > 0) exp_cnt--;
      check_count(i < 255 ? "R9 count after dec" : "R10 dec at zero");
    end

    // R8 clear by write
    host(2'd1, 1'b0, 1'b1, 16'h0, v);
    exp_cnt = 0; exp_exc = 0;
    check_count("R8 clear");

    // R11 entry and decrement in the same cycle
    for (int i = 0; i < 3; i++) begin
      push(16'h0F00 + 16'(i), 16'h5500 + 16'(i), 1'b0, 2'd0, 1'b0, 1'b0, 16'h0);
      model_inc(); exp_tail = exp_tail + 16'd2;
    end
    push(16'hFFFF, 16'h1234, 1'b1, 2'd2, 1'b1, 1'b0, 16'h0);
    exp_tail = exp_tail + 16'd2;
    check_count("R11 inc with dec");
    push(16'h0001, 16'h4321, 1'b1, 2'd2, 1'b0, 1'b1, 16'h0);
    exp_tail = exp_tail + 16'd2;
    check_count("R11 inc with dec via write");

    // R10 entry at zero with decrement
    host(2'd1, 1'b0, 1'b1, 16'h0, v);
    exp_cnt = 0; exp_exc = 0;
    push(16'h2222, 16'h3333, 1'b1, 2'd2, 1'b1, 1'b0, 16'h0);
    exp_tail = exp_tail + 16'd2;
    check_count("R11 R10 zero with inc and dec");

    // R8 clear beats completing entry
    push(16'h0042, 16'h0043, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0);
    model_inc(); exp_tail = exp_tail + 16'd2;
    push(16'h0044, 16'h0045, 1'b1, 2'd1, 1'b0, 1'b1, 16'h0);
    exp_tail = exp_tail + 16'd2;
    exp_cnt = 0; exp_exc = 0;
    check_count("R8 clear wins");

    // R12 load beats advance
    push(16'h0046, 16'h0047, 1'b1, 2'd0, 1'b0, 1'b1, 16'h8000);
    exp_tail = 16'h8000;
    model_inc();
    host(2'd0, 1'b1, 1'b0, 16'h0, v);
    chk("R12 load wins", 32'(v), 32'h8000);
    check_count("R5 count after load");
    push(16'h0048, 16'h0049, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0);
    exp_tail = exp_tail + 16'd2; model_inc();
    host(2'd0, 1'b1, 1'b0, 16'h0, v);
    chk("R12 R5 after load", 32'(v), 32'h8002);

    // R6 writes to the unused code change nothing
    host(2'd3, 1'b0, 1'b1, 16'hFFFF, v);
    check_count("R6 unused write count");
    host(2'd0, 1'b1, 1'b0, 16'h0, v);
    chk("R6 unused write tail", 32'(v), 32'h8002);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule